// File: doc/BRIEF.md
# Trailing Bit Manipulation Unit

This unit is an execution-stage functional unit. In one clock it computes one of nine transforms that use the carry or borrow chain to find the lowest set or lowest clear bit of an operand. It also offers a field extract controlled by a start position and a length. The operand width is a parameter, 32 or 64.

An issuing stage presents an operand, a 4-bit operation code and, for the extract, a start position and a length, all qualified by a valid strobe. One clock later the unit returns the result with a valid strobe, a zero flag and a carry flag. The unit accepts a new operation every cycle. The outputs keep their last values while no operation is in flight.

Top module: `trailbit_unit`

## Requirements
- R1: Operation code 0 (field extract) returns `(src >> start) & ((1 << len) - 1)`, where start and len are the 8-bit unsigned inputs `inStart` and `inLen`.
- R2: For field extract, a len of 0 returns 0, a len equal to or above WIDTH returns every bit from start upward, and a start equal to or above WIDTH returns 0.
- R3: Code 1 returns `x & (x+1)`, code 2 returns `x | ~(x+1)`, and code 3 returns `~x & (x+1)`, all arithmetic modulo 2^WIDTH.
- R4: Code 4 returns `x ^ (x+1)`, code 5 returns `x | (x+1)`, and code 8 returns `~x | (x+1)`.
- R5: Code 6 returns `x | (x-1)`, code 7 returns `~x | (x-1)`, and code 9 returns `~x & (x-1)`.
- R6: `outCarry` is 1 when codes 1, 2, 3, 4, 5 or 8 receive an all-ones operand, or when codes 6, 7 or 9 receive a zero operand. It is 0 in every other case, including code 0.
- R7: Whenever `outValid` is 1, `outZero` is 1 exactly when `outResult` is 0.
- R8: A request with `inValid` high at a clock edge produces `outValid` high, with its result, right after the next edge. Without a request, `outValid` is 0 after that edge. Back-to-back requests give back-to-back results in order.
- R9: While `outValid` is 0, `outResult` keeps its previous value.
- R10: Codes 10 to 15 return a result of 0, with `outCarry` 0 and `outZero` 1.
- R11: While `rstN` is low, `outValid`, `outResult`, `outZero` and `outCarry` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| inOp | input | 4 | Operation code |
| inSrc | input | WIDTH | Source operand |
| inStart | input | ARG_W | Extract start bit position |
| inLen | input | ARG_W | Extract field length |
| outValid | output | 1 | Result strobe, one cycle after the request |
| outResult | output | WIDTH | Registered result |
| outZero | output | 1 | Result equals zero |
| outCarry | output | 1 | Increment overflowed or decrement borrowed |

## Verification
A wrong decode strobe corrupts the result. Inverting the operand or the adjusted value, or picking the wrong merge or the wrong adjust direction, shows at `outResult` in the cycle right after the request. Only operands whose low bits exercise the carry chain expose such a fault, so each code is driven with zero, all ones, a lone high bit, and mixed patterns. A stuck valid register or a load enable that ignores the strobe shows within one cycle: a result appears unannounced, goes missing, or changes while `outValid` is low.

// File: rtl/trailbit_pkg.sv
package trailbit_pkg;

  typedef enum logic [3:0] {
    OP_FIELD      = 4'd0,
    OP_FILL_CLR   = 4'd1,
    OP_ISO_CLR    = 4'd2,
    OP_ISO_CLR_N  = 4'd3,
    OP_MSK_CLR    = 4'd4,
    OP_SET_CLR    = 4'd5,
    OP_FILL_SET   = 4'd6,
    OP_ISO_SET_N  = 4'd7,
    OP_MSK_ONES_N = 4'd8,
    OP_MSK_ZEROS  = 4'd9
  } opSel_e;

  typedef enum logic [1:0] {
    MERGE_AND = 2'd0,
    MERGE_OR  = 2'd1,
    MERGE_XOR = 2'd2
  } merge_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   load;
    logic   legal;
    logic   isField;
    logic   useInc;
    logic   invSrc;
    logic   invAdj;
    merge_e merge;
  } strobes_t;

endpackage

// File: rtl/trailbit_ctrl.sv
module trailbit_ctrl
  import trailbit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [3:0] inOp,
  output strobes_t   strb,
  output logic       outValid
);

  always_comb begin
    strb         = '0;
    strb.load    = inValid;
    strb.legal   = 1'b1;
    strb.useInc  = 1'b1;
    strb.merge   = MERGE_AND;
    case (opSel_e'(inOp))
      OP_FIELD:      strb.isField = 1'b1;
      OP_FILL_CLR:   strb.merge = MERGE_AND;
      OP_ISO_CLR:    begin strb.invAdj = 1'b1; strb.merge = MERGE_OR; end
      OP_ISO_CLR_N:  begin strb.invSrc = 1'b1; strb.merge = MERGE_AND; end
      OP_MSK_CLR:    strb.merge = MERGE_XOR;
      OP_SET_CLR:    strb.merge = MERGE_OR;
      OP_FILL_SET:   begin strb.useInc = 1'b0; strb.merge = MERGE_OR; end
      OP_ISO_SET_N:  begin strb.useInc = 1'b0; strb.invSrc = 1'b1; strb.merge = MERGE_OR; end
      OP_MSK_ONES_N: begin strb.invSrc = 1'b1; strb.merge = MERGE_OR; end
      OP_MSK_ZEROS:  begin strb.useInc = 1'b0; strb.invSrc = 1'b1; strb.merge = MERGE_AND; end
      default:       strb.legal = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/trailbit_dpath.sv
module trailbit_dpath
  import trailbit_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int ARG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic [WIDTH-1:0] inSrc,
  input  logic [ARG_W-1:0] inStart,
  input  logic [ARG_W-1:0] inLen,
  output logic [WIDTH-1:0] outResult,
  output logic             outZero,
  output logic             outCarry
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] adjVal, opA, opB, bitVal, fieldMask, fieldVal, nextRes;
  logic             startOk, nextCarry;

  // Field mask: bit i set when i < len
  for (genvar i = 0; i < WIDTH; i++) begin : g_mask
    assign fieldMask[i] = (32'(inLen) > 32'(i));
  end

  assign startOk  = (32'(inStart) < 32'(WIDTH));
  assign fieldVal = startOk ? ((inSrc >> inStart) & fieldMask) : '0;

  assign adjVal = strb.useInc ? (inSrc + ONE) : (inSrc - ONE);
  assign opA    = strb.invSrc ? ~inSrc : inSrc;
  assign opB    = strb.invAdj ? ~adjVal : adjVal;

  always_comb begin
    case (strb.merge)
      MERGE_OR:  bitVal = opA | opB;
      MERGE_XOR: bitVal = opA ^ opB;
      default:   bitVal = opA & opB;
    endcase
  end

  assign nextRes   = !strb.legal ? '0 : (strb.isField ? fieldVal : bitVal);
  assign nextCarry = strb.legal && !strb.isField &&
                     (strb.useInc ? (&inSrc) : ~(|inSrc));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outResult <= '0;
      outZero   <= 1'b0;
      outCarry  <= 1'b0;
    end else if (strb.load) begin
      outResult <= nextRes;
      outZero   <= (nextRes == '0);
      outCarry  <= nextCarry;
    end
  end

endmodule

// File: rtl/trailbit_unit.sv
module trailbit_unit
  import trailbit_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int ARG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [3:0]       inOp,
  input  logic [WIDTH-1:0] inSrc,
  input  logic [ARG_W-1:0] inStart,
  input  logic [ARG_W-1:0] inLen,
  output logic             outValid,
  output logic [WIDTH-1:0] outResult,
  output logic             outZero,
  output logic             outCarry
);

  strobes_t strb;

  trailbit_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inOp    (inOp),
    .strb    (strb),
    .outValid(outValid)
  );

  trailbit_dpath #(.WIDTH(WIDTH), .ARG_W(ARG_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .inSrc    (inSrc),
    .inStart  (inStart),
    .inLen    (inLen),
    .outResult(outResult),
    .outZero  (outZero),
    .outCarry (outCarry)
  );

endmodule

// File: rtl/trailbit_chk.sv
module trailbit_chk #(
  parameter int WIDTH = 32,
  parameter int ARG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [3:0]       inOp,
  input logic [WIDTH-1:0] inSrc,
  input logic [ARG_W-1:0] inLen,
  input logic             outValid,
  input logic [WIDTH-1:0] outResult,
  input logic             outZero,
  input logic             outCarry
);

  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ALL1 = '1;

  logic             prevValid;
  logic [3:0]       prevOp;
  logic [WIDTH-1:0] prevSrc;
  logic [ARG_W-1:0] prevLen;
  logic             prevInc, prevDec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevValid <= 1'b0;
      prevOp    <= '0;
      prevSrc   <= '0;
      prevLen   <= '0;
    end else begin
      prevValid <= inValid;
      prevOp    <= inOp;
      prevSrc   <= inSrc;
      prevLen   <= inLen;
    end
  end

  assign prevInc = (prevOp inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd8});
  assign prevDec = (prevOp inside {4'd6, 4'd7, 4'd9});

  a_r8_latency: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r8_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outResult));
  a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outZero == (outResult == '0)));
  a_r3_fill_clear: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && prevOp == 4'd1) |-> (outResult == (prevSrc & (prevSrc + ONE))));
  a_r6_carry_inc: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && prevInc && prevSrc == ALL1) |-> outCarry);
  a_r6_carry_dec: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && prevDec && prevSrc == '0) |-> outCarry);
  a_r10_illegal: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && prevOp >= 4'd10) |-> (outResult == '0 && !outCarry));
  a_r2_len_zero: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && prevOp == 4'd0 && prevLen == '0) |-> (outResult == '0));

endmodule

bind trailbit_unit trailbit_chk #(.WIDTH(WIDTH), .ARG_W(ARG_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inOp     (inOp),
  .inSrc    (inSrc),
  .inLen    (inLen),
  .outValid (outValid),
  .outResult(outResult),
  .outZero  (outZero),
  .outCarry (outCarry)
);

// File: tb/sim_trailbit_unit.sv
module sim_trailbit_unit;

  localparam int W = 32;
  localparam int A = 8;

  typedef struct {
    logic [W-1:0] res;
    logic         zero;
    logic         carry;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [3:0]   inOp = '0;
  logic [W-1:0] inSrc = '0;
  logic [A-1:0] inStart = '0;
  logic [A-1:0] inLen = '0;
  logic         outValid;
  logic [W-1:0] outResult;
  logic         outZero;
  logic         outCarry;

  int nChecks = 0;
  int nFail = 0;
  int nPushed = 0;
  int nPopped = 0;
  bit done = 0;
  item_t scoreQ[$];
  logic [W-1:0] lastRes = '0;

  always #4 clk = ~clk;

  trailbit_unit #(.WIDTH(W), .ARG_W(A)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inSrc(inSrc),
    .inStart(inStart), .inLen(inLen), .outValid(outValid),
    .outResult(outResult), .outZero(outZero), .outCarry(outCarry)
  );

  function automatic logic [W-1:0] model(input logic [3:0] op, input logic [W-1:0] x,
                                         input logic [A-1:0] st, input logic [A-1:0] ln);
    logic [W-1:0] p, m;
    p = x + W'(1);
    m = x - W'(1);
    case (op)
      4'd0: begin
        if (int'(st) >= W || ln == 0) return '0;
        if (int'(ln) >= W) return x >> st;
        return (x >> st) & W'((64'd1 << ln) - 64'd1);
      end
      4'd1: return x & p;
      4'd2: return x | ~p;
      4'd3: return ~x & p;
      4'd4: return x ^ p;
      4'd5: return x | p;
      4'd6: return x | m;
      4'd7: return ~x | m;
      4'd8: return ~x | p;
      4'd9: return ~x & m;
      default: return '0;
    endcase
  endfunction

  function automatic logic carryModel(input logic [3:0] op, input logic [W-1:0] x);
    if (op inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd8}) return (x == '1);
    if (op inside {4'd6, 4'd7, 4'd9}) return (x == '0);
    return 1'b0;
  endfunction

  function automatic string opTag(input logic [3:0] op);
    if (op inside {4'd1, 4'd2, 4'd3}) return "R3";
    if (op inside {4'd4, 4'd5, 4'd8}) return "R4";
    if (op inside {4'd6, 4'd7, 4'd9}) return "R5";
    if (op >= 4'd10) return "R10";
    return "R1";
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [W-1:0] x,
                       input logic [A-1:0] st, input logic [A-1:0] ln, input string tag);
    item_t it;
    @(negedge clk);
    inValid = 1'b1; inOp = op; inSrc = x; inStart = st; inLen = ln;
    it.res   = model(op, x, st, ln);
    it.zero  = (it.res == '0);
    it.carry = carryModel(op, x);
    it.tag   = tag;
    scoreQ.push_back(it);
    nPushed++;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (scoreQ.size() == 0) begin
        check(1'b0, "R8", W'(outValid), W'(0));
      end else begin
        item_t e;
        e = scoreQ.pop_front();
        nPopped++;
        check(outResult === e.res, e.tag, outResult, e.res);
        check(outCarry === e.carry, "R6", W'(outCarry), W'(e.carry));
        check(outZero === e.zero, (e.tag == "R10") ? "R10" : "R7", W'(outZero), W'(e.zero));
        lastRes = e.res;
      end
    end
  end

  initial begin
    logic [W-1:0] pats[6];
    pats[0] = '0;          pats[1] = '1;
    pats[2] = 32'h0000_00FF; pats[3] = 32'hA5A5_0F00;
    pats[4] = 32'h8000_0000; pats[5] = 32'h1234_5677;

    // R11: reset state
    repeat (3) @(negedge clk);
    check(outValid === 1'b0 && outZero === 1'b0 && outCarry === 1'b0, "R11",
          {outValid, outZero, outCarry}, '0);
    check(outResult === '0, "R11", outResult, '0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: field extract
    drive(4'd0, 32'hDEAD_BEEF, 8'd4, 8'd8, "R1");
    drive(4'd0, 32'hDEAD_BEEF, 8'd0, 8'd32, "R1");
    drive(4'd0, 32'hDEAD_BEEF, 8'd31, 8'd1, "R1");
    drive(4'd0, 32'hFFFF_FFFF, 8'd3, 8'd5, "R1");
    // R2: extract edges
    drive(4'd0, 32'hDEAD_BEEF, 8'd8, 8'd0, "R2");
    drive(4'd0, 32'hDEAD_BEEF, 8'd8, 8'd40, "R2");
    drive(4'd0, 32'hDEAD_BEEF, 8'd32, 8'd4, "R2");
    drive(4'd0, 32'hDEAD_BEEF, 8'd200, 8'd255, "R2");
    idle();

    // R3, R4, R5, R6: every transform over several operands, back to back
    for (int op = 1; op <= 9; op++) begin
      for (int k = 0; k < 6; k++) begin
        drive(4'(op), pats[k], 8'd0, 8'd0, opTag(4'(op)));
      end
    end
    idle();

    // R10: unused codes
    for (int op = 10; op <= 15; op++) begin
      drive(4'(op), 32'h1234_5678, 8'd2, 8'd4, "R10");
      idle();
    end

    // R9: hold while idle
    drive(4'd5, 32'h0000_0F0F, 8'd0, 8'd0, "R4");
    idle();
    @(negedge clk);
    inSrc = 32'hFFFF_0000; inOp = 4'd1;
    repeat (3) @(negedge clk);
    check(outValid === 1'b0 && outResult === lastRes, "R9", outResult, lastRes);

    // R8: every request returned one cycle later, in order
    repeat (2) @(negedge clk);
    check(nPushed == nPopped && scoreQ.size() == 0, "R8", W'(nPopped), W'(nPushed));
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule